// File: doc/BRIEF.md
# Floppy Controller Port Glue

This block sits between a CPU bus and a floppy disk controller core. It decodes seven port offsets inside the CPU's top I/O page. For each one it produces the strobe, readback value or control register effect that belongs to that port. A control register drives the two drive motors, the drive select and the interrupt/DMA enable. The same register also carries an active-low soft-reset bit.

A second port holds the controller's reset pin. Both reset controls act only on a transition of their bit, never on its level. Entering a reset pends it and clears the interrupt flag. Leaving a pending reset emits a one-cycle reset pulse toward the controller core. Leaving a soft reset also raises the interrupt flag, but only when drive 0 is the selected drive. Repeated writes with the same bit value do nothing.

Reads return the DMA byte, a fixed DMA-request indication, the interrupt flag, the core's main status, the core's data register or a disk-changed flag. Reads of the data port, and both reads and writes of it, are passed to the core as single-cycle strobes.

Top module: `fdc_port_glue`

## Requirements
- R1: With `bus_sel` high, exactly seven offsets are decoded: 0x80, 0x88, 0x90, 0x98, 0xA0, 0xA8 and 0xB8. `bus_rd_hit` is high for a read of any of these offsets and low for every other offset, and low whenever `bus_sel` is low.
- R2: `core_data_rd` and `core_data_wr` are high in the same cycle as a read or a write of 0xA8, and at no other time. `dma_ack` is high for a read of 0x80 or 0x88. `dma_last` is high only for a read of 0x88.
- R3: A write to 0x90 loads, from the next cycle, `motor_b` from bit 5, `motor_a` from bit 4, `dma_int_en` from bit 3 and `drive_sel` from bits 1:0.
- R4: A write to 0x90 with bit 2 low, while no soft reset is pending, makes a soft reset pending and clears `irq`. A further write with bit 2 low produces no pulse.
- R5: A write to 0x90 with bit 2 high while a soft reset is pending gives a one-cycle `core_soft_rst` pulse in the next cycle. It ends the pending state and sets `irq` only if the written drive select is 0, clearing it otherwise. With no soft reset pending, bit 2 high gives no pulse and leaves `irq` unchanged.
- R6: A write to 0xA0 with bit 6 high, while the pin reset is released, raises `core_pin_reset` and clears `irq`. Repeating that write changes nothing.
- R7: A write to 0xA0 with bit 6 low while `core_pin_reset` is high has three effects. It lowers `core_pin_reset`, gives a one-cycle `core_hard_rst` pulse in the next cycle, and clears `motor_a`, `motor_b`, `dma_int_en` and `drive_sel`. With the pin reset released, such a write does nothing.
- R8: `bus_rdata` is combinational and depends on the offset read. 0x98 returns 0x40 when `irq` is set and 0x00 otherwise. 0x90 returns 0x40. 0xB8 returns 0x00. 0xA0 returns `core_status`. 0xA8 returns `core_rdata`. 0x80 and 0x88 return `dma_byte`.
- R9: After reset every output register is zero, no reset is pending and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access falls in the top I/O page |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Offset within the top page |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rd_hit | output | 1 | Read hit one of the decoded ports |
| core_status | input | 8 | Main status from the controller core |
| core_rdata | input | 8 | Data register value from the controller core |
| dma_byte | input | 8 | Current byte of the DMA buffer |
| core_data_wr | output | 1 | Write strobe to the core data port |
| core_data_rd | output | 1 | Read strobe to the core data port |
| core_wdata | output | 8 | Write data to the core |
| dma_ack | output | 1 | DMA byte read, advance the buffer pointer |
| dma_last | output | 1 | DMA read was the terminal-count port |
| core_soft_rst | output | 1 | One-cycle soft reset pulse |
| core_hard_rst | output | 1 | One-cycle hard reset pulse |
| core_pin_reset | output | 1 | Controller reset pin level |
| motor_a | output | 1 | Drive A motor on |
| motor_b | output | 1 | Drive B motor on |
| dma_int_en | output | 1 | Interrupt and DMA enable |
| drive_sel | output | 2 | Selected drive |
| irq | output | 1 | Interrupt flag |

## Verification
The decoder is swept over all 256 offsets for both reads and writes, and once more with the page select low. This separates the seven real ports from near neighbours and from accesses outside the page. The control port is written with every byte value whose bit 2 is high. That tells each output field apart and shows that no soft reset fires without a pending entry. Soft-reset entry, repeat entry and release are run for each of the four drive selects, which separates the drive-0 interrupt from the other three. Pin-reset entry, repeat and release are run after the control fields have been loaded, and a second release with no entry pending follows. Together these distinguish edge action from level action and confirm that the hard reset clears the fields.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;

    localparam int DW    = 8;
    localparam int SEL_W = 2;

    // control port bit positions
    localparam int B_MOTOR_B = 5;
    localparam int B_MOTOR_A = 4;
    localparam int B_DMA_EN  = 3;
    localparam int B_SOFT_N  = 2;
    // pin reset port bit position
    localparam int B_PIN     = 6;
    // readback flag position for request and interrupt ports
    localparam int B_FLAG    = 6;

    typedef struct packed {
        logic rd_dma;
        logic rd_dma_last;
        logic rd_drq;
        logic rd_irq;
        logic rd_stat;
        logic rd_data;
        logic rd_chg;
        logic wr_ctrl;
        logic wr_pin;
        logic wr_data;
    } port_hits_t;

    typedef struct packed {
        logic             motor_b;
        logic             motor_a;
        logic             dma_en;
        logic [SEL_W-1:0] drv_sel;
        logic             soft_pend;
        logic             pin_pend;
        logic             irq;
        logic             soft_pulse;
        logic             hard_pulse;
    } ctrl_state_t;

endpackage

// File: rtl/fdc_glue_decode.sv
module fdc_glue_decode
    import fdc_glue_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [AW-1:0] OFS_DMA  = 8'h80,
    parameter logic [AW-1:0] OFS_TC   = 8'h88,
    parameter logic [AW-1:0] OFS_CTRL = 8'h90,
    parameter logic [AW-1:0] OFS_IRQ  = 8'h98,
    parameter logic [AW-1:0] OFS_STAT = 8'hA0,
    parameter logic [AW-1:0] OFS_DATA = 8'hA8,
    parameter logic [AW-1:0] OFS_CHG  = 8'hB8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output port_hits_t    hits
);

    localparam int N_RD = 7;
    localparam int N_WR = 3;

    logic rd_en, wr_en;
    assign rd_en = sel && rd;
    assign wr_en = sel && wr;

    always_comb begin
        hits             = '0;
        hits.rd_dma      = rd_en && (addr == OFS_DMA || addr == OFS_TC);
        hits.rd_dma_last = rd_en && (addr == OFS_TC);
        hits.rd_drq      = rd_en && (addr == OFS_CTRL);
        hits.rd_irq      = rd_en && (addr == OFS_IRQ);
        hits.rd_stat     = rd_en && (addr == OFS_STAT);
        hits.rd_data     = rd_en && (addr == OFS_DATA);
        hits.rd_chg      = rd_en && (addr == OFS_CHG);
        hits.wr_ctrl     = wr_en && (addr == OFS_CTRL);
        hits.wr_pin      = wr_en && (addr == OFS_STAT);
        hits.wr_data     = wr_en && (addr == OFS_DATA);
    end

    logic [N_RD-1:0] rd_vec;
    logic [N_WR-1:0] wr_vec;
    assign rd_vec = {hits.rd_dma, hits.rd_drq, hits.rd_irq, hits.rd_stat,
                     hits.rd_data, hits.rd_chg, 1'b0};
    assign wr_vec = {hits.wr_ctrl, hits.wr_pin, hits.wr_data};

    // R1: at most one read port and one write port per access
    p_one_read_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_vec));
    p_one_write_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));
    // R2: terminal-count read is always a DMA read
    p_last_is_dma_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hits.rd_dma_last |-> hits.rd_dma);

endmodule

// File: rtl/fdc_glue_ctrl.sv
module fdc_glue_ctrl
    import fdc_glue_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_pin,
    input  logic [DW-1:0] wdata,
    output ctrl_state_t   st
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.soft_pulse = 1'b0;
        st_d.hard_pulse = 1'b0;

        if (wr_ctrl) begin
            st_d.motor_b = wdata[B_MOTOR_B];
            st_d.motor_a = wdata[B_MOTOR_A];
            st_d.dma_en  = wdata[B_DMA_EN];
            st_d.drv_sel = wdata[SEL_W-1:0];
            if (wdata[B_SOFT_N]) begin
                if (st_q.soft_pend) begin
                    st_d.soft_pend  = 1'b0;
                    st_d.soft_pulse = 1'b1;
                    st_d.irq        = (wdata[SEL_W-1:0] == '0);
                end
            end else if (!st_q.soft_pend) begin
                st_d.soft_pend = 1'b1;
                st_d.irq       = 1'b0;
            end
        end

        if (wr_pin) begin
            if (wdata[B_PIN]) begin
                if (!st_q.pin_pend) begin
                    st_d.pin_pend = 1'b1;
                    st_d.irq      = 1'b0;
                end
            end else if (st_q.pin_pend) begin
                st_d.pin_pend   = 1'b0;
                st_d.hard_pulse = 1'b1;
                st_d.motor_a    = 1'b0;
                st_d.motor_b    = 1'b0;
                st_d.dma_en     = 1'b0;
                st_d.drv_sel    = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    // R4: entering soft reset leaves the interrupt clear
    p_soft_entry_clears_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.soft_pend) |-> !st_q.irq);
    // R5: interrupt only rises on a soft reset release with drive 0
    p_irq_rise_drive0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> (st_q.soft_pulse && st_q.drv_sel == '0));
    // R5: soft reset pulse lasts one cycle
    p_soft_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.soft_pulse |=> !st_q.soft_pulse);
    // R6: entering pin reset leaves the interrupt clear
    p_pin_entry_clears_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pin_pend) |-> !st_q.irq);
    // R7: hard reset pulse comes with cleared control fields and released pin
    p_hard_clears_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hard_pulse |-> (!st_q.motor_a && !st_q.motor_b && !st_q.dma_en
                             && st_q.drv_sel == '0 && !st_q.pin_pend));
    p_hard_follows_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hard_pulse |-> $fell(st_q.pin_pend));

endmodule

// File: rtl/fdc_glue_rdmux.sv
module fdc_glue_rdmux
    import fdc_glue_pkg::*;
(
    input  port_hits_t    hits,
    input  logic          irq,
    input  logic [DW-1:0] core_status,
    input  logic [DW-1:0] core_rdata,
    input  logic [DW-1:0] dma_byte,
    output logic [DW-1:0] rdata,
    output logic          rd_hit
);

    localparam logic [DW-1:0] FLAG = DW'(1) << B_FLAG;

    always_comb begin
        rdata = '0;
        unique case (1'b1)
            hits.rd_dma:  rdata = dma_byte;
            hits.rd_drq:  rdata = FLAG;
            hits.rd_irq:  rdata = irq ? FLAG : '0;
            hits.rd_stat: rdata = core_status;
            hits.rd_data: rdata = core_rdata;
            default:      rdata = '0;
        endcase
    end

    assign rd_hit = hits.rd_dma | hits.rd_drq | hits.rd_irq | hits.rd_stat
                  | hits.rd_data | hits.rd_chg;

endmodule

// File: rtl/fdc_port_glue.sv
module fdc_port_glue
    import fdc_glue_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [7:0]   bus_addr,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    output logic         bus_rd_hit,
    input  logic [7:0]   core_status,
    input  logic [7:0]   core_rdata,
    input  logic [7:0]   dma_byte,
    output logic         core_data_wr,
    output logic         core_data_rd,
    output logic [7:0]   core_wdata,
    output logic         dma_ack,
    output logic         dma_last,
    output logic         core_soft_rst,
    output logic         core_hard_rst,
    output logic         core_pin_reset,
    output logic         motor_a,
    output logic         motor_b,
    output logic         dma_int_en,
    output logic [1:0]   drive_sel,
    output logic         irq
);

    port_hits_t  hits;
    ctrl_state_t st;

    fdc_glue_decode #(.AW(8)) u_decode (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (bus_sel),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .addr (bus_addr),
        .hits (hits)
    );

    fdc_glue_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(hits.wr_ctrl),
        .wr_pin (hits.wr_pin),
        .wdata  (bus_wdata),
        .st     (st)
    );

    fdc_glue_rdmux u_rdmux (
        .hits       (hits),
        .irq        (st.irq),
        .core_status(core_status),
        .core_rdata (core_rdata),
        .dma_byte   (dma_byte),
        .rdata      (bus_rdata),
        .rd_hit     (bus_rd_hit)
    );

    assign core_data_wr   = hits.wr_data;
    assign core_data_rd   = hits.rd_data;
    assign core_wdata     = bus_wdata;
    assign dma_ack        = hits.rd_dma;
    assign dma_last       = hits.rd_dma_last;
    assign core_soft_rst  = st.soft_pulse;
    assign core_hard_rst  = st.hard_pulse;
    assign core_pin_reset = st.pin_pend;
    assign motor_a        = st.motor_a;
    assign motor_b        = st.motor_b;
    assign dma_int_en     = st.dma_en;
    assign drive_sel      = st.drv_sel;
    assign irq            = st.irq;

    // R9: no reset pulse while the system reset is applied
    p_no_pulse_in_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (!core_soft_rst && !core_hard_rst));
    // R2: core data strobes never overlap
    p_data_strobes_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_data_wr && core_data_rd) || (bus_wr && bus_rd));

endmodule

// File: tb/fdc_port_glue_bench.sv
module fdc_port_glue_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel, bus_wr, bus_rd;
    logic [7:0] bus_addr, bus_wdata;
    logic [7:0] bus_rdata;
    logic       bus_rd_hit;
    logic [7:0] core_status, core_rdata, dma_byte;
    logic       core_data_wr, core_data_rd, dma_ack, dma_last;
    logic [7:0] core_wdata;
    logic       core_soft_rst, core_hard_rst, core_pin_reset;
    logic       motor_a, motor_b, dma_int_en, irq;
    logic [1:0] drive_sel;

    int checks = 0;
    int errors = 0;

    // expected model
    logic       e_ma, e_mb, e_en, e_sp, e_pp, e_irq;
    logic [1:0] e_sel;
    logic       saw_soft, saw_hard;

    always #4 clk = ~clk;

    fdc_port_glue u_fdc_port_glue (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = 8'h00; bus_wdata = 8'h00;
    endtask

    task automatic model_write(logic [7:0] a, logic [7:0] d);
        if (a == 8'h90) begin
            e_mb = d[5]; e_ma = d[4]; e_en = d[3]; e_sel = d[1:0];
            if (d[2]) begin
                if (e_sp) begin e_sp = 1'b0; e_irq = (d[1:0] == 2'd0); end
            end else if (!e_sp) begin e_sp = 1'b1; e_irq = 1'b0; end
        end else if (a == 8'hA0) begin
            if (d[6]) begin
                if (!e_pp) begin e_pp = 1'b1; e_irq = 1'b0; end
            end else if (e_pp) begin
                e_pp = 1'b0; e_ma = 1'b0; e_mb = 1'b0; e_en = 1'b0; e_sel = 2'd0;
            end
        end
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        saw_soft = core_soft_rst;
        saw_hard = core_hard_rst;
        model_write(a, d);
        @(negedge clk);
        idle();
    endtask

    task automatic check_fields(string req);
        check(req, {motor_b, motor_a, dma_int_en, drive_sel},
                   {e_mb, e_ma, e_en, e_sel});
        check(req, {core_pin_reset, irq}, {e_pp, e_irq});
    endtask

    task automatic read_port(logic [7:0] a, output logic [7:0] d, output logic hit);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata; hit = bus_rd_hit;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       hit;
        idle();
        core_status = 8'h5A; core_rdata = 8'hC3; dma_byte = 8'h96;
        e_ma = 0; e_mb = 0; e_en = 0; e_sp = 0; e_pp = 0; e_irq = 0; e_sel = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        check("R9", {motor_b, motor_a, dma_int_en, drive_sel, core_pin_reset, irq,
                     core_soft_rst, core_hard_rst}, 32'h0);

        // R1 R2 R8 decode sweep over all offsets
        for (int a = 0; a < 256; a++) begin
            logic exp_hit;
            logic [7:0] exp_d;
            exp_hit = (a == 8'h80 || a == 8'h88 || a == 8'h90 || a == 8'h98 ||
                       a == 8'hA0 || a == 8'hA8 || a == 8'hB8);
            exp_d = 8'h00;
            if (a == 8'h80 || a == 8'h88) exp_d = dma_byte;
            if (a == 8'h90) exp_d = 8'h40;
            if (a == 8'hA0) exp_d = core_status;
            if (a == 8'hA8) exp_d = core_rdata;
            @(negedge clk);
            bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 8'(a);
            #1;
            check("R1", bus_rd_hit, exp_hit);
            if (exp_hit) check("R8", bus_rdata, exp_d);
            check("R2", {core_data_rd, core_data_wr, dma_ack, dma_last},
                        {a == 8'hA8, 1'b0, a == 8'h80 || a == 8'h88, a == 8'h88});
            bus_rd = 1'b0;
            if (a != 8'h90 && a != 8'hA0) begin
                bus_wr = 1'b1; bus_wdata = 8'hE7;
                #1;
                check("R2", {core_data_wr, core_data_rd}, {a == 8'hA8, 1'b0});
                if (a == 8'hA8) check("R2", core_wdata, 8'hE7);
            end
            @(negedge clk);
            idle();
            #1;
            check("R1", {bus_rd_hit, core_data_wr, core_data_rd, dma_ack}, 4'b0);
        end
        // R1 page select low
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b1; bus_addr = 8'hA8;
        #1;
        check("R1", {bus_rd_hit, core_data_rd}, 2'b0);
        @(negedge clk);
        idle();

        // R3 every control byte with soft reset bit high
        for (int d = 0; d < 256; d++) begin
            if (d[2]) begin
                do_write(8'h90, 8'(d));
                check("R5", saw_soft, 1'b0);
                check_fields("R3");
            end
        end

        // R4 R5 R6 soft reset per drive select
        for (int s = 0; s < 4; s++) begin
            do_write(8'h90, 8'h38 | 8'(s));
            check("R4", {saw_soft, irq}, 2'b0);
            do_write(8'h90, 8'h30 | 8'(s));
            check("R4", saw_soft, 1'b0);
            do_write(8'h90, 8'h34 | 8'(s));
            check("R5", saw_soft, 1'b1);
            check_fields("R5");
            check("R5", irq, s == 0);
            read_port(8'h98, rd, hit);
            check("R8", rd, (s == 0) ? 8'h40 : 8'h00);
            #1;
            check("R5", core_soft_rst, 1'b0);
            do_write(8'h90, 8'h34 | 8'(s));
            check("R5", saw_soft, 1'b0);
            check("R5", irq, s == 0);
        end

        // R6 R7 pin reset after irq raised with drive 0
        do_write(8'h90, 8'h30);
        do_write(8'h90, 8'h3C);
        check("R5", irq, 1'b1);
        do_write(8'hA0, 8'h40);
        check("R6", {core_pin_reset, irq, saw_hard}, 3'b100);
        check_fields("R6");
        do_write(8'h90, 8'h3F);
        do_write(8'hA0, 8'h40);
        check("R6", saw_hard, 1'b0);
        check_fields("R6");
        do_write(8'hA0, 8'h00);
        check("R7", saw_hard, 1'b1);
        check("R7", {motor_b, motor_a, dma_int_en, drive_sel, core_pin_reset}, 6'b0);
        check_fields("R7");
        do_write(8'h90, 8'h3B);
        do_write(8'hA0, 8'h00);
        check("R7", saw_hard, 1'b0);
        check_fields("R7");
        @(negedge clk);
        check("R7", core_hard_rst, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule